// File: doc/BRIEF.md
# Eight-Operation Integer ALU with Zero Flag

This block is the arithmetic and logic stage of a small 32-bit integer datapath. Each cycle it takes two operands and a 3-bit operation select. It computes one of eight results: addition, subtraction, a signed or unsigned less-than test, bitwise AND or OR, a move of operand B into the upper half of the word, or the bitwise inverse of operand A. It also raises a flag when the result is all zeros.

The caller does all the surrounding work. It picks between register and immediate values for the operands and turns instruction fields into the 3-bit select. The ALU logic itself is combinational. In keeping with the FPGA target, the result and the flag are captured in an output register, so a value presented before a rising edge shows up right after that edge. There is no carry, overflow or exception output.

Top module: `octo_alu`

## Requirements
- R1: Select code 0 gives opnd_a + opnd_b modulo 2^32.
- R2: Select code 1 gives opnd_a - opnd_b modulo 2^32.
- R3: Select code 2 gives 1 when opnd_a is less than opnd_b, both read as two's complement, and 0 otherwise. Bits 31:1 are zero. For example, 0xFFFFFFFF against 0x00000001 gives 1.
- R4: Select code 3 gives 1 when opnd_a is less than opnd_b, both read as unsigned, and 0 otherwise. Bits 31:1 are zero.
- R5: Select code 4 gives the bitwise AND of the operands. Select code 5 gives their bitwise OR.
- R6: Select code 6 gives opnd_b shifted left by 16 places, with zeros in bits 15:0. The value of opnd_a has no effect on the result.
- R7: Select code 7 gives the bitwise complement of opnd_a. The value of opnd_b has no effect on the result.
- R8: is_zero is 1 exactly when the 32-bit result is all zeros.
- R9: The result and flag for inputs sampled at a rising edge appear right after that edge. They hold steady until the next edge, whatever the inputs do in between.
- R10: While rst is high at a rising edge, result becomes 0 and is_zero becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 3 | Operation select, codes 0 to 7 as in R1 to R7 |
| result | output | 32 | Registered result |
| is_zero | output | 1 | Registered flag, high when result is zero |

## Verification
Each operation is first tried with directed corners:
- Wraparound sums and differences with a zero result separate modular arithmetic from saturating or widened arithmetic, and also exercise the flag.
- Operand pairs that differ only in the sign bit tell the signed comparison apart from the unsigned one, and equal operands catch a less-or-equal mistake.
- For the upper-move and inverse operations, the unused operand is changed while the other is held fixed, which shows it is ignored.

Two thousand random operand pairs spread over all eight codes then check the result against a behavioural model. Two further tests change the inputs between edges to show that the outputs hold, and apply reset in mid-run.

// File: rtl/octo_alu_pkg.sv
package octo_alu_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_LT_S  = 3'd2,
    OP_LT_U  = 3'd3,
    OP_AND   = 3'd4,
    OP_OR    = 3'd5,
    OP_UPPER = 3'd6,
    OP_INV   = 3'd7
  } alu_op_e;

endpackage

// File: rtl/octo_alu_arith.sv
module octo_alu_arith #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] diff_o,
  output logic              lt_s_o,
  output logic              lt_u_o
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0] sub_ext;

  // One subtractor serves the difference and both comparisons.
  assign sub_ext = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
  assign sum_o   = a_i + b_i;
  assign diff_o  = sub_ext[DATA_W-1:0];

  // No carry out of a - b means a borrow, so a < b unsigned.
  assign lt_u_o = ~sub_ext[DATA_W];

  // When the signs differ, the negative operand is the smaller one.
  assign lt_s_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : sub_ext[MSB];

endmodule

// File: rtl/octo_alu_bitops.sv
module octo_alu_bitops #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned UPPER_SH = DATA_W / 2
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] upper_o,
  output logic [DATA_W-1:0] inv_o
);

  localparam int unsigned KEEP_W = DATA_W - UPPER_SH;

  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign inv_o = ~a_i;

  // Fixed-distance move into the upper bits: pure wiring, zeros below.
  assign upper_o = {b_i[KEEP_W-1:0], {UPPER_SH{1'b0}}};

endmodule

// File: rtl/octo_alu_zdet.sv
module octo_alu_zdet #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  output logic              zero_o
);

  localparam int unsigned N_CHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W   = N_CHUNK * CHUNK_W;

  logic [PAD_W-1:0]   padded;
  logic [N_CHUNK-1:0] chunk_any;

  assign padded = PAD_W'(val_i);

  // Two-level OR tree: wide LUT-sized groups, then one final combine.
  for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
    assign chunk_any[g] = |padded[g*CHUNK_W +: CHUNK_W];
  end

  assign zero_o = ~|chunk_any;

endmodule

// File: rtl/octo_alu.sv
module octo_alu
  import octo_alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned UPPER_SH = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [OP_W-1:0]   op_code,
  output logic [DATA_W-1:0] result,
  output logic              is_zero
);

  logic [DATA_W-1:0] sum_v, diff_v, and_v, or_v, upper_v, inv_v;
  logic              lt_s, lt_u;
  logic [DATA_W-1:0] res_d;
  logic              zero_d;

  octo_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .sum_o  (sum_v),
    .diff_o (diff_v),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  octo_alu_bitops #(.DATA_W(DATA_W), .UPPER_SH(UPPER_SH)) u_bitops (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .and_o   (and_v),
    .or_o    (or_v),
    .upper_o (upper_v),
    .inv_o   (inv_v)
  );

  always_comb begin
    case (alu_op_e'(op_code))
      OP_ADD:   res_d = sum_v;
      OP_SUB:   res_d = diff_v;
      OP_LT_S:  res_d = DATA_W'(lt_s);
      OP_LT_U:  res_d = DATA_W'(lt_u);
      OP_AND:   res_d = and_v;
      OP_OR:    res_d = or_v;
      OP_UPPER: res_d = upper_v;
      OP_INV:   res_d = inv_v;
      default:  res_d = '0;
    endcase
  end

  octo_alu_zdet #(.DATA_W(DATA_W)) u_zdet (
    .val_i  (res_d),
    .zero_o (zero_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      is_zero <= 1'b1;
    end else begin
      result  <= res_d;
      is_zero <= zero_d;
    end
  end

endmodule

// File: rtl/octo_alu_chk.sv
module octo_alu_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned UPPER_SH = DATA_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [2:0]        op_code,
  input logic [DATA_W-1:0] result,
  input logic              is_zero
);

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (result == '0) && is_zero);

  a_r8_zero_matches: assert property (@(posedge clk) disable iff (rst)
    is_zero == (result == '0));

  a_r1_add: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd0) |=> result == $past(opnd_a) + $past(opnd_b));

  a_r2_sub: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd1) |=> result == $past(opnd_a) - $past(opnd_b));

  a_r3_signed_lt: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd2) |=>
      result == DATA_W'($signed($past(opnd_a)) < $signed($past(opnd_b))));

  a_r4_unsigned_lt: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd3) |=> result == DATA_W'($past(opnd_a) < $past(opnd_b)));

  a_r5_and: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd4) |=> result == ($past(opnd_a) & $past(opnd_b)));

  a_r5_or: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd5) |=> result == ($past(opnd_a) | $past(opnd_b)));

  a_r6_upper: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd6) |=> result == ($past(opnd_b) << UPPER_SH));

  a_r7_invert: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd7) |=> result == ~$past(opnd_a));

endmodule

bind octo_alu octo_alu_chk #(.DATA_W(DATA_W), .UPPER_SH(UPPER_SH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .op_code (op_code),
  .result  (result),
  .is_zero (is_zero)
);

// File: tb/octo_alu_tb.sv
`timescale 1ns/1ps
module octo_alu_tb;

  localparam real CLK_PER = 5.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [2:0]  op_code = '0;
  logic [31:0] result;
  logic        is_zero;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PER/2) clk = ~clk;

  octo_alu u_dut (
    .clk     (clk),
    .rst     (rst),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_code (op_code),
    .result  (result),
    .is_zero (is_zero)
  );

  function automatic logic [31:0] model(input logic [2:0] op,
                                        input logic [31:0] a,
                                        input logic [31:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return (sa < sb) ? 32'd1 : 32'd0;
      3'd3: return ({32'd0, a} < {32'd0, b}) ? 32'd1 : 32'd0;
      3'd4: return a & b;
      3'd5: return a | b;
      3'd6: return {b[15:0], 16'h0000};
      default: return ~a;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Compare outputs for the previous stimulus, then apply the next one.
  task automatic flush_check();
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, result, e);
      check("R8", {31'd0, is_zero}, {31'd0, e == 32'd0});
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [31:0] a,
                      input logic [31:0] b);
    @(negedge clk);
    flush_check();
    op_code = op;
    opnd_a  = a;
    opnd_b  = b;
    exp_q.push_back(model(op, a, b));
    tag_q.push_back(tag_of(op));
  endtask

  task automatic drain();
    @(negedge clk);
    flush_check();
  endtask

  initial begin
    logic [31:0] keep_r, keep_z;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", result, 32'd0);
    check("R10", {31'd0, is_zero}, 32'd1);
    rst = 1'b0;

    // R1 and R2 wraparound, R8 flag
    step(3'd0, 32'hFFFF_FFFF, 32'h0000_0001);
    step(3'd0, 32'h1234_5678, 32'h1111_1111);
    step(3'd1, 32'h0000_0005, 32'h0000_0005);
    step(3'd1, 32'h0000_0000, 32'h0000_0001);
    // R3 / R4: sign-bit pairs and equality
    step(3'd2, 32'hFFFF_FFFF, 32'h0000_0001);
    step(3'd3, 32'hFFFF_FFFF, 32'h0000_0001);
    step(3'd2, 32'h8000_0000, 32'h7FFF_FFFF);
    step(3'd3, 32'h8000_0000, 32'h7FFF_FFFF);
    step(3'd2, 32'h0000_0007, 32'h0000_0007);
    step(3'd3, 32'h0000_0003, 32'h0000_0009);
    step(3'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    // R5
    step(3'd4, 32'hF0F0_F0F0, 32'hFF00_FF00);
    step(3'd4, 32'hAAAA_AAAA, 32'h5555_5555);
    step(3'd5, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    // R6: A changes, B fixed; result must not move
    step(3'd6, 32'h0000_0000, 32'hDEAD_BEEF);
    step(3'd6, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
    step(3'd6, 32'h1234_5678, 32'hFFFF_0000);
    // R7: B changes, A fixed
    step(3'd7, 32'h0F0F_0000, 32'h0000_0000);
    step(3'd7, 32'h0F0F_0000, 32'hFFFF_FFFF);
    step(3'd7, 32'hFFFF_FFFF, 32'h1357_9BDF);
    drain();

    // Random sweep over all codes
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 9 == 0) rb = ra;
      if (i % 13 == 0) rb = ra ^ 32'h8000_0000;
      step(3'(i % 8), ra, rb);
    end
    drain();

    // R9: inputs change between edges, outputs hold
    step(3'd0, 32'h0000_0010, 32'h0000_0020);
    @(negedge clk);
    flush_check();
    keep_r = result;
    keep_z = {31'd0, is_zero};
    opnd_a = 32'h0;
    opnd_b = 32'h0;
    op_code = 3'd1;
    #1;
    check("R9", result, keep_r);
    check("R9", {31'd0, is_zero}, keep_z);
    check("R9", keep_r, 32'h0000_0030);

    // R10: reset mid-run overrides a nonzero pending result
    op_code = 3'd7;
    opnd_a  = 32'h0;
    rst     = 1'b1;
    @(negedge clk);
    check("R10", result, 32'd0);
    check("R10", {31'd0, is_zero}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R7", result, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule